// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a serial flash sequencer and decides, for each flash access the sequencer is about to issue, whether that access touches memory that has been fenced off. It holds six protected ranges. Each range is described by a first page and a last page, both counted in 4 KiB pages, with the last page included. Each range has its own read-guard enable and its own write-guard enable. A read request is checked only against ranges whose read guard is on. A write or erase request is checked only against ranges whose write guard is on.

Firmware programs the ranges through a small register port and then raises a lock input. From then until reset the ranges cannot be changed. The sequencer presents a request as a start byte address, a byte count minus one and an access kind, and holds a strobe high. One clock later the block gives a registered violation flag. That flag stays frozen for as long as the strobe stays high.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range register reads back as zero and `viol` is low.
- R2: Range i sits at byte offset 4*i (i = 0..5). Each 32-bit word holds the first page in bits 13:0, the read-guard enable in bit 15, the last page in bits 29:16 and the write-guard enable in bit 31. Bits 14 and 30 read as zero. A misaligned offset, or an offset of 0x18 or above, reads as zero, and a write to it changes no range.
- R3: A range covers the bytes from first_page*4096 through last_page*4096+4095, with both ends included. A request covers req_addr through req_addr+req_len_m1, computed one bit wider than the address so that it does not wrap. A request violates a guarded range when at least one byte is common to both.
- R4: A read request (`req_kind` = 2'b00) is checked only against ranges whose read-guard bit is set.
- R5: A write (2'b01), an erase (2'b10) or the spare code 2'b11 is checked only against ranges whose write-guard bit is set.
- R6: A range with both guard bits clear is ignored. A range whose first page is greater than its last page covers no byte.
- R7: `viol` is updated at the clock edge that first samples `req_valid` high, using the ranges as they stand at that edge. It keeps that value while `req_valid` stays high, even if ranges are rewritten meanwhile. It is low from the edge that samples `req_valid` low.
- R8: Once `lock_in` has been sampled high, every register write is ignored until reset. This includes a write presented at the same edge. After reset, writes work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_in | input | 1 | Freezes the range registers until reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (5) | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request strobe, held for the life of a request |
| req_addr | input | 26 | First byte address of the request |
| req_len_m1 | input | LEN_W (16) | Byte count of the request minus one |
| req_kind | input | 2 | 00 read, 01 write, 10 erase, 11 spare (treated as write) |
| viol | output | 1 | Registered violation flag |

## Verification
Register read data is combinational, so the bench drives `cfg_addr` after a falling edge and samples a moment later, before the next rising edge. A register write takes effect at the single rising edge during which `cfg_we` is high. The violation flag is due exactly one rising edge after the strobe first goes high. The bench therefore raises `req_valid` at a falling edge and samples `viol` at the next falling edge. It also samples at further falling edges while the strobe is held, and at the falling edge after the strobe is dropped, to confirm the hold-and-clear timing.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  // Register word geometry; bit positions are fixed by the register format
  localparam int PAGE_W     = 14;
  localparam int PAGE_SHIFT = 12;
  localparam int ADDR_W     = PAGE_W + PAGE_SHIFT;
  localparam int WORD_W     = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_ERASE = 2'b10,
    ACC_SPARE = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic              wr_guard;
    logic [PAGE_W-1:0] last_pg;
    logic              rd_guard;
    logic [PAGE_W-1:0] first_pg;
  } range_t;

  localparam int RANGE_BITS = $bits(range_t);

  function automatic logic [WORD_W-1:0] range_to_word(range_t r);
    return {r.wr_guard, 1'b0, r.last_pg, r.rd_guard, 1'b0, r.first_pg};
  endfunction

  function automatic range_t word_to_range(logic [WORD_W-1:0] w);
    range_t r;
    r.first_pg = w[PAGE_W-1:0];
    r.rd_guard = w[15];
    r.last_pg  = w[16 +: PAGE_W];
    r.wr_guard = w[31];
    return r;
  endfunction

  // First and last byte of a page, one bit wider than a flash address
  function automatic logic [ADDR_W:0] page_lo_byte(logic [PAGE_W-1:0] pg);
    return {1'b0, pg, {PAGE_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W:0] page_hi_byte(logic [PAGE_W-1:0] pg);
    return {1'b0, pg, {PAGE_SHIFT{1'b1}}};
  endfunction

  // Two inclusive spans share at least one byte
  function automatic logic spans_meet(logic [ADDR_W:0] a_lo, logic [ADDR_W:0] a_hi,
                                      logic [ADDR_W:0] b_lo, logic [ADDR_W:0] b_hi);
    return (a_lo <= b_hi) && (b_lo <= a_hi);
  endfunction

  function automatic logic kind_reads(logic [1:0] k);
    return k == ACC_READ;
  endfunction

endpackage

// File: rtl/fpg_regfile.sv
module fpg_regfile
  import fpg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int CFG_AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output range_t            ranges [NUM_RANGES],
  output logic              locked
);

  localparam int IDX_W = CFG_AW - 2;
  localparam logic [IDX_W:0] SLOT_COUNT = NUM_RANGES[IDX_W:0];

  logic [IDX_W-1:0] slot;
  logic             slot_ok;
  logic             wr_fire;

  assign slot    = cfg_addr[CFG_AW-1:2];
  assign slot_ok = (cfg_addr[1:0] == 2'b00) && ({1'b0, slot} < SLOT_COUNT);
  assign wr_fire = cfg_we && slot_ok && !locked && !lock_in;

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= locked | lock_in;
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        ranges[g] <= '0;
      else if (wr_fire && slot == IDX_W'(g))
        ranges[g] <= word_to_range(cfg_wdata);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_RANGES; k++)
      if (slot_ok && slot == IDX_W'(k))
        cfg_rdata = range_to_word(ranges[k]);
  end

  // Flattened copy of all ranges, for the freeze checks
  logic [NUM_RANGES*RANGE_BITS-1:0] range_image;
  always_comb
    for (int k = 0; k < NUM_RANGES; k++)
      range_image[k*RANGE_BITS +: RANGE_BITS] = ranges[k];

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || lock_in) |=> $stable(range_image));

  // R2
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && slot_ok) |=> $stable(range_image));

endmodule

// File: rtl/fpg_range_cmp.sv
module fpg_range_cmp
  import fpg_pkg::*;
(
  input  range_t          rng,
  input  logic [ADDR_W:0] req_lo,
  input  logic [ADDR_W:0] req_hi,
  input  logic [1:0]      req_kind,
  output logic            hit
);

  logic guard_on;
  logic non_empty;
  logic overlap;

  assign guard_on  = kind_reads(req_kind) ? rng.rd_guard : rng.wr_guard;
  assign non_empty = rng.first_pg <= rng.last_pg;
  assign overlap   = spans_meet(req_lo, req_hi,
                                page_lo_byte(rng.first_pg), page_hi_byte(rng.last_pg));
  assign hit       = guard_on && non_empty && overlap;

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import fpg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int LEN_W      = 16,
  parameter int CFG_AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [1:0]        req_kind,
  output logic              viol
);

  range_t ranges [NUM_RANGES];
  logic   locked;

  fpg_regfile #(.NUM_RANGES(NUM_RANGES), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_in   (lock_in),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ranges    (ranges),
    .locked    (locked)
  );

  // Request span, one bit wider so the end never wraps
  logic [ADDR_W:0] req_lo;
  logic [ADDR_W:0] req_hi;
  assign req_lo = {1'b0, req_addr};
  assign req_hi = req_lo + (ADDR_W+1)'(req_len_m1);

  logic [NUM_RANGES-1:0] hit_vec;
  logic                  hit_any;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    fpg_range_cmp u_cmp (
      .rng      (ranges[g]),
      .req_lo   (req_lo),
      .req_hi   (req_hi),
      .req_kind (req_kind),
      .hit      (hit_vec[g])
    );

    // R6
    empty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ranges[g].first_pg > ranges[g].last_pg) |-> !hit_vec[g]);

    // R4
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_reads(req_kind) && hit_vec[g]) |-> ranges[g].rd_guard);

    // R5
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!kind_reads(req_kind) && hit_vec[g]) |-> ranges[g].wr_guard);
  end

  assign hit_any = |hit_vec;

  // Capture on the first strobe cycle, hold while strobe stays high
  logic held_q;
  logic strobe_first;
  assign strobe_first = req_valid && !held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      viol   <= 1'b0;
    end else begin
      held_q <= req_valid;
      if (strobe_first)    viol <= hit_any;
      else if (!req_valid) viol <= 1'b0;
    end
  end

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !viol);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && held_q) |=> $stable(viol));

endmodule

// File: tb/flash_range_guard_test.sv
`timescale 1ns/1ps
module flash_range_guard_test;
  import fpg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_in = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_len_m1 = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        viol;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  flash_range_guard uut (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_len_m1(req_len_m1),
    .req_kind(req_kind), .viol(viol)
  );

  // {wr_guard, last page, rd_guard, first page} in the register layout
  function automatic logic [31:0] mkw(bit wg, int last, bit rg, int first);
    return {wg, 1'b0, last[13:0], rg, 1'b0, first[13:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [4:0] offs, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = offs; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read_chk(string tag, logic [4:0] offs, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = offs;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic run_req(string tag, logic [25:0] a, logic [15:0] l, logic [1:0] k, bit exp);
    @(negedge clk);
    req_addr = a; req_len_m1 = l; req_kind = k; req_valid = 1'b1;
    @(negedge clk);
    check(tag, {31'd0, viol}, {31'd0, exp});
    req_valid = 1'b0;
  endtask

  task automatic load_ranges();
    cfg_write(5'h00, mkw(1, 2, 0, 1));           // bytes 0x1000..0x2FFF write-guarded
    cfg_write(5'h04, mkw(0, 4, 1, 4));           // 0x4000..0x4FFF read-guarded
    cfg_write(5'h08, mkw(1, 9, 1, 8));           // 0x8000..0x9FFF both
    cfg_write(5'h0C, mkw(0, 16, 0, 16));         // guards off
    cfg_write(5'h10, mkw(1, 31, 1, 32));         // first > last: empty
    cfg_write(5'h14, mkw(1, 16383, 0, 16383));   // top page write-guarded
  endtask

  // {addr, len_m1, kind, expected}
  localparam int NV = 25;
  localparam logic [44:0] VEC [NV] = '{
    {26'h0000000, 16'h0FFF, 2'd1, 1'b0},
    {26'h0000001, 16'h0FFF, 2'd1, 1'b1},
    {26'h0000FFF, 16'h0000, 2'd0, 1'b0},
    {26'h0001800, 16'h003F, 2'd0, 1'b0},
    {26'h0001800, 16'h003F, 2'd2, 1'b1},
    {26'h0003000, 16'h0FFF, 2'd1, 1'b0},
    {26'h0003FFF, 16'h0000, 2'd0, 1'b0},
    {26'h0003FFF, 16'h0001, 2'd0, 1'b1},
    {26'h0004FFF, 16'h0000, 2'd0, 1'b1},
    {26'h0004800, 16'h00FF, 2'd1, 1'b0},
    {26'h0005000, 16'h0FFF, 2'd0, 1'b0},
    {26'h0009FFF, 16'h0000, 2'd0, 1'b1},
    {26'h0009FFF, 16'h0000, 2'd1, 1'b1},
    {26'h000A000, 16'h0FFF, 2'd2, 1'b0},
    {26'h0010000, 16'h0FFF, 2'd1, 1'b0},
    {26'h0010000, 16'h003F, 2'd0, 1'b0},
    {26'h001F800, 16'h1FFF, 2'd1, 1'b0},
    {26'h3FFF000, 16'h0000, 2'd1, 1'b1},
    {26'h3FFF000, 16'h0000, 2'd0, 1'b0},
    {26'h0006000, 16'h1FFF, 2'd0, 1'b0},
    {26'h0006000, 16'h2000, 2'd0, 1'b1},
    {26'h0003000, 16'h3000, 2'd0, 1'b1},
    {26'h0001000, 16'h0000, 2'd3, 1'b1},
    {26'h0004000, 16'h0000, 2'd3, 1'b0},
    {26'h3FFFF00, 16'hFFFF, 2'd1, 1'b1}
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 viol after reset", {31'd0, viol}, 32'd0);
    for (int i = 0; i < 6; i++)
      cfg_read_chk("R1 range zero after reset", 5'(i * 4), 32'h0);

    load_ranges();
    cfg_read_chk("R2 readback slot0", 5'h00, 32'h8002_0001);
    cfg_read_chk("R2 readback slot5", 5'h14, 32'hBFFF_3FFF);

    // Vector table: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e;
      e = VEC[v];
      run_req($sformatf("R3/R4/R5/R6 vector %0d", v), e[44:19], e[18:3], e[2:1], e[0]);
    end

    // R2: unused bits read zero
    cfg_write(5'h0C, 32'hFFFF_FFFF);
    cfg_read_chk("R2 unused bits masked", 5'h0C, 32'hBFFF_BFFF);
    cfg_write(5'h0C, mkw(0, 16, 0, 16));
    // R2: misaligned and out-of-range offsets
    cfg_write(5'h05, 32'h0000_0000);
    cfg_read_chk("R2 misaligned write ignored", 5'h04, 32'h0004_8004);
    cfg_read_chk("R2 misaligned read zero", 5'h06, 32'h0);
    cfg_write(5'h18, 32'hFFFF_FFFF);
    cfg_read_chk("R2 offset 0x18 reads zero", 5'h18, 32'h0);
    cfg_read_chk("R2 offset 0x1C reads zero", 5'h1C, 32'h0);
    run_req("R2 out-of-range write touched no range", 26'h0010000, 16'h0, 2'd1, 1'b0);

    // R7: hold while strobe high, even when the range is cleared meanwhile
    @(negedge clk);
    req_addr = 26'h0001800; req_len_m1 = 16'h0; req_kind = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    check("R7 viol one edge after strobe", {31'd0, viol}, 32'd1);
    cfg_we = 1'b1; cfg_addr = 5'h00; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7 viol held after range rewrite", {31'd0, viol}, 32'd1);
    @(negedge clk);
    check("R7 viol still held", {31'd0, viol}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R7 viol low after strobe drop", {31'd0, viol}, 32'd0);
    run_req("R7 new strobe sees cleared range", 26'h0001800, 16'h0, 2'd1, 1'b0);
    cfg_write(5'h00, mkw(1, 2, 0, 1));

    // R8: lock with a write at the same edge
    @(negedge clk);
    lock_in = 1'b1; cfg_we = 1'b1; cfg_addr = 5'h08; cfg_wdata = 32'h0;
    @(negedge clk);
    lock_in = 1'b0; cfg_we = 1'b0;
    cfg_read_chk("R8 same-edge write blocked", 5'h08, 32'h8009_8008);
    cfg_write(5'h08, 32'h0);
    cfg_read_chk("R8 later write blocked", 5'h08, 32'h8009_8008);
    run_req("R8 locked range still guards", 26'h0009000, 16'h0, 2'd0, 1'b1);

    // R8: reset releases the lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_read_chk("R1 range cleared by reset", 5'h08, 32'h0);
    cfg_write(5'h08, mkw(1, 9, 1, 8));
    cfg_read_chk("R8 write works after reset", 5'h08, 32'h8009_8008);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule